// File: doc/BRIEF.md
# Flash Sector Address Generator

This block sits between the register file of a paged flash controller and its data mover. Software writes block, page and buffer settings into a small bank of address registers. When the controller strobes a command (load, program, copy-back or block erase), the generator turns those registers into an absolute 512-byte sector index, a sector count and a buffer selector. It presents them on registered outputs with a one-cycle valid pulse.

The geometry is fixed at four sectors per 2 KB page and 64 pages per block. Block numbers come from a 12-bit register field. On higher-density parts a single extra bit, whose position depends on the device identifier, extends that field.

The block also decodes writes to the boot window. A two-write sequence there reads the next page of the boot area into data buffer 0 and steps the page register forward by one page. Two single-write codes request a warm reset and ask for the identity words to be shown.

Top module: `flash_sector_addr_gen`

## Requirements
- R1: For load and program, the sector index is block×256 + page_reg[7:2]×4 + page_reg[1:0]. The block is taken from address register 0 and the page from address register 7. The block number is block_reg[11:0], ORed with the density mask when block_reg[15] is 1.
- R2: When dev_id[3] is 1, the density mask is 1 << (6 + dev_id[6:4]). When dev_id[3] is 0, the mask is 0.
- R3: Copy-back (cmd_op 2) reports the source sector from registers 0 and 7 on op_sector, and the destination sector from registers 2 and 3 on op_dst_sector, using the same formula. Every other operation drives op_dst_sector to 0.
- R4: Block erase (cmd_op 3) reports op_sector = block×256 and op_count = 256. The page register plays no part.
- R5: A write with reg_sel 8 stores reg_wdata[11:8] as the buffer selector (op_buf) and reg_wdata[1:0] as the sector count, where 0 stands for 4. Load, program and copy report that count and selector. After reset the count is 1 and the selector is 0. Writes with reg_sel 9 to 15 change nothing.
- R6: After a command strobe, op_valid is high for exactly one cycle, starting on the next clock edge. op_kind carries the cmd_op code (0 load, 1 program, 2 copy, 3 erase).
- R7: A boot write of 0x00E0 arms the sequence. If the next boot write is 0x0000, the block reports a load (kind 0) of the current page: count 4, op_buf 4'b1000. The page register then becomes (page_reg[7:0] + 4) mod 256, and its upper bits are cleared.
- R8: Any boot write made while armed disarms the sequence and is not decoded as a command. For example, 0x00F0 written while armed causes no warm reset.
- R9: A boot write of 0x00F0 when not armed pulses warm_rst for one cycle. It also returns all address registers to 0, the count to 1 and the selector to 0.
- R10: A boot write of 0x0090 when not armed pulses id_valid for one cycle, with id_bytes = {wp_stat[7:0], dev_id[7:0], mfr_id[7:0]}. Byte 0 holds the manufacturer ID.
- R11: If the completing boot write and a command strobe fall in the same cycle, the boot load is reported and the command is dropped.
- R12: During reset and right after it, op_valid, warm_rst and id_valid are 0, and op_sector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | 0-7 address registers, 8 buffer/count register |
| reg_wdata | input | 16 | Register write data |
| boot_we | input | 1 | Boot window write strobe |
| boot_wdata | input | 16 | Boot window write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 load, 1 program, 2 copy-back, 3 erase |
| dev_id | input | 16 | Device identifier |
| mfr_id | input | 16 | Manufacturer identifier |
| wp_stat | input | 16 | Write-protect status word |
| op_valid | output | 1 | One-cycle pulse for a new operation |
| op_kind | output | 2 | Operation code of the reported operation |
| op_sector | output | 22 | Start sector index |
| op_dst_sector | output | 22 | Copy-back destination sector |
| op_count | output | 9 | Sector count |
| op_buf | output | 4 | Buffer selector: bit3 data/boot, bit2 buffer, bits1:0 sector offset |
| warm_rst | output | 1 | Warm reset request pulse |
| id_valid | output | 1 | Identity words valid pulse |
| id_bytes | output | 24 | {wp, device, manufacturer} low bytes |

## Verification
The bench aims at the block-bit extension. It sets block_reg[15] with density codes on and off. A generator that ignored the enable or misplaced the shift would report a sector far from the expected one. The boot sequence is exercised at page 0xFC and 0xFE, where a missing wrap or a kept upper byte would show up on the next boot load. It is also exercised with armed writes of 0x00F0 and 0x0005, where a design that still decoded those writes would raise a spurious warm reset or load. Count code 0, erase on extended blocks and a boot load colliding with a strobe complete the directed set. Random register, command and boot traffic is then checked against a bench model.

// File: rtl/fsag_pkg.sv
// Package: shared geometry constants and the operation code for the
// flash sector address generator. Assumes 512-byte sectors.
package fsag_pkg;
    localparam int AREG_W     = 16;                      // address register width
    localparam int BLK_FIELD  = 12;                      // plain block field width
    localparam int PG_W       = 6;                       // log2 pages per block
    localparam int SIP_W      = 2;                       // log2 sectors per page
    localparam int DENS_BASE  = 6;                       // base shift of the density bit
    localparam int DENS_SEL_W = 3;                       // width of density code in dev id
    localparam int BLKN_W     = DENS_BASE + (1 << DENS_SEL_W);
    localparam int SECT_W     = BLKN_W + PG_W + SIP_W;
    localparam int CNT_W      = PG_W + SIP_W + 1;
    localparam int SEL_W      = 4;
    localparam int BUF_W      = 4;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_PROG  = 2'd1,
        OP_COPY  = 2'd2,
        OP_ERASE = 2'd3
    } fsag_op_e;
endpackage

// File: rtl/fsag_sector_calc.sv
// Module: fsag_sector_calc
// Combinational translation of a block register and a page register into
// an absolute sector index and the first sector of the block.
// Assumes the page register's low SIP_W bits select the sector within a
// page and the next PG_W bits select the page in the block.
module fsag_sector_calc
    import fsag_pkg::*;
#(
    parameter int P_AREG_W     = AREG_W,
    parameter int P_BLK_FIELD  = BLK_FIELD,
    parameter int P_PG_W       = PG_W,
    parameter int P_SIP_W      = SIP_W,
    parameter int P_DENS_BASE  = DENS_BASE,
    parameter int P_DENS_SEL_W = DENS_SEL_W,
    parameter int P_DENS_EN    = 3,
    parameter int P_DENS_LO    = 4
) (
    input  logic [P_AREG_W-1:0] blk_reg,
    input  logic [P_AREG_W-1:0] pg_reg,
    input  logic [P_AREG_W-1:0] dev_id,
    output logic [P_DENS_BASE+(1<<P_DENS_SEL_W)+P_PG_W+P_SIP_W-1:0] sector,
    output logic [P_DENS_BASE+(1<<P_DENS_SEL_W)+P_PG_W+P_SIP_W-1:0] blk_start
);
    localparam int LBLK_W = P_DENS_BASE + (1 << P_DENS_SEL_W);
    localparam int INBLK_W = P_PG_W + P_SIP_W;

    logic [LBLK_W-1:0]       dens_mask;
    logic [LBLK_W-1:0]       blk_num;
    logic [P_DENS_SEL_W-1:0] dens_code;

    // Purpose: pick the extra block bit from the device identifier.
    always_comb begin
        dens_code = dev_id[P_DENS_LO +: P_DENS_SEL_W];
        dens_mask = '0;
        if (dev_id[P_DENS_EN])
            dens_mask = LBLK_W'(1) << (P_DENS_BASE + int'(dens_code));
    end

    // Purpose: form the block number and the two sector results.
    always_comb begin
        blk_num = LBLK_W'(blk_reg[P_BLK_FIELD-1:0]);
        if (blk_reg[P_AREG_W-1])
            blk_num = blk_num | dens_mask;
        sector    = {blk_num, pg_reg[INBLK_W-1:0]};
        blk_start = {blk_num, {INBLK_W{1'b0}}};
    end
endmodule

// File: rtl/fsag_regs.sv
// Module: fsag_regs
// Holds the eight address registers and the buffer/count register.
// Supports the boot-sequence page advance and a warm clear.
// Assumes a register write takes precedence over the page advance,
// and a warm clear takes precedence over both.
module fsag_regs
    import fsag_pkg::*;
#(
    parameter int P_AREG_W  = AREG_W,
    parameter int P_NREG    = 8,
    parameter int P_SEL_W   = SEL_W,
    parameter int P_BUF_W   = BUF_W,
    parameter int P_SIP_W   = SIP_W,
    parameter int P_PG_W    = PG_W,
    parameter int P_SRC_BLK = 0,
    parameter int P_SRC_PG  = 7,
    parameter int P_DST_BLK = 2,
    parameter int P_DST_PG  = 3,
    parameter int P_BUF_SEL = 8,
    parameter int P_BUF_LO  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [P_SEL_W-1:0]   reg_sel,
    input  logic [P_AREG_W-1:0]  reg_wdata,
    input  logic                 page_adv,
    input  logic                 warm_clr,
    output logic [P_AREG_W-1:0]  blk_src,
    output logic [P_AREG_W-1:0]  pg_src,
    output logic [P_AREG_W-1:0]  blk_dst,
    output logic [P_AREG_W-1:0]  pg_dst,
    output logic [P_BUF_W-1:0]   buf_sel,
    output logic [P_SIP_W:0]     buf_cnt
);
    localparam int WRAP_W = P_PG_W + P_SIP_W;
    localparam logic [WRAP_W-1:0] PAGE_STEP = WRAP_W'(1 << P_SIP_W);
    localparam logic [P_SIP_W:0]  FULL_CNT  = (P_SIP_W+1)'(1 << P_SIP_W);

    logic [P_NREG*P_AREG_W-1:0] areg_flat;

    for (genvar gi = 0; gi < P_NREG; gi++) begin : g_areg
        logic [P_AREG_W-1:0] q;
        // Purpose: load, clear or (page register only) auto-advance one register.
        always_ff @(posedge clk) begin
            if (!rst_n || warm_clr)
                q <= '0;
            else if (reg_we && reg_sel == P_SEL_W'(gi))
                q <= reg_wdata;
            else if (gi == P_SRC_PG && page_adv)
                q <= P_AREG_W'(q[WRAP_W-1:0] + PAGE_STEP);
        end
        assign areg_flat[gi*P_AREG_W +: P_AREG_W] = q;
    end

    assign blk_src = areg_flat[P_SRC_BLK*P_AREG_W +: P_AREG_W];
    assign pg_src  = areg_flat[P_SRC_PG*P_AREG_W  +: P_AREG_W];
    assign blk_dst = areg_flat[P_DST_BLK*P_AREG_W +: P_AREG_W];
    assign pg_dst  = areg_flat[P_DST_PG*P_AREG_W  +: P_AREG_W];

    // Purpose: hold the buffer selector and the decoded sector count.
    always_ff @(posedge clk) begin
        if (!rst_n || warm_clr) begin
            buf_sel <= '0;
            buf_cnt <= (P_SIP_W+1)'(1);
        end else if (reg_we && reg_sel == P_SEL_W'(P_BUF_SEL)) begin
            buf_sel <= reg_wdata[P_BUF_LO +: P_BUF_W];
            if (reg_wdata[P_SIP_W-1:0] == '0)
                buf_cnt <= FULL_CNT;
            else
                buf_cnt <= {1'b0, reg_wdata[P_SIP_W-1:0]};
        end
    end

    assert_page_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (page_adv && !warm_clr && !(reg_we && reg_sel == P_SEL_W'(P_SRC_PG)))
        |=> (pg_src == P_AREG_W'($past(pg_src[WRAP_W-1:0]) + PAGE_STEP)));

    assert_warm_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        warm_clr |=> (pg_src == '0 && blk_src == '0 && buf_sel == '0
                      && buf_cnt == (P_SIP_W+1)'(1)));

    assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_cnt != '0 && buf_cnt <= FULL_CNT));
endmodule

// File: rtl/fsag_boot_seq.sv
// Module: fsag_boot_seq
// Decodes writes to the boot window. A first write of the arm code
// makes the next write a second cycle, which is consumed whatever its
// value and triggers a page load only for the load code.
// Assumes one boot write per strobe cycle.
module fsag_boot_seq #(
    parameter int              P_W         = 16,
    parameter logic [P_W-1:0]  P_ARM_CODE  = 16'h00E0,
    parameter logic [P_W-1:0]  P_LOAD_CODE = 16'h0000,
    parameter logic [P_W-1:0]  P_WARM_CODE = 16'h00F0,
    parameter logic [P_W-1:0]  P_ID_CODE   = 16'h0090
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           boot_we,
    input  logic [P_W-1:0] boot_wdata,
    output logic           load_fire,
    output logic           warm_fire,
    output logic           id_fire
);
    logic armed_q;

    // Purpose: track whether the next boot write is a second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (boot_we)
            armed_q <= !armed_q && (boot_wdata == P_ARM_CODE);
    end

    // Purpose: decode the one-shot requests for this cycle.
    always_comb begin
        load_fire = boot_we &&  armed_q && (boot_wdata == P_LOAD_CODE);
        warm_fire = boot_we && !armed_q && (boot_wdata == P_WARM_CODE);
        id_fire   = boot_we && !armed_q && (boot_wdata == P_ID_CODE);
    end

    assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_we && armed_q) |=> !armed_q);

    assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_we && !armed_q && boot_wdata == P_ARM_CODE) |=> armed_q);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_we |=> $stable(armed_q));
endmodule

// File: rtl/flash_sector_addr_gen.sv
// Module: flash_sector_addr_gen (top)
// Turns the controller's address and buffer registers into a registered
// sector index, count and buffer selector for the data mover, and
// decodes the boot-window command sequence.
// Assumes cmd_op is sampled only when cmd_valid is high.
module flash_sector_addr_gen
    import fsag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [AREG_W-1:0] reg_wdata,
    input  logic              boot_we,
    input  logic [AREG_W-1:0] boot_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [AREG_W-1:0] dev_id,
    input  logic [AREG_W-1:0] mfr_id,
    input  logic [AREG_W-1:0] wp_stat,
    output logic              op_valid,
    output logic [1:0]        op_kind,
    output logic [SECT_W-1:0] op_sector,
    output logic [SECT_W-1:0] op_dst_sector,
    output logic [CNT_W-1:0]  op_count,
    output logic [BUF_W-1:0]  op_buf,
    output logic              warm_rst,
    output logic              id_valid,
    output logic [23:0]       id_bytes
);
    localparam logic [CNT_W-1:0] PAGE_CNT  = CNT_W'(1 << SIP_W);
    localparam logic [CNT_W-1:0] BLOCK_CNT = CNT_W'(1 << (PG_W + SIP_W));
    localparam logic [BUF_W-1:0] BOOT_BUF  = BUF_W'(1 << (BUF_W-1));

    logic              load_fire, warm_fire, id_fire;
    logic [AREG_W-1:0] blk_src, pg_src, blk_dst, pg_dst;
    logic [BUF_W-1:0]  buf_sel;
    logic [SIP_W:0]    buf_cnt;
    logic [SECT_W-1:0] src_sector, src_blk_start, dst_sector, dst_blk_start;
    fsag_op_e          op_code;

    fsag_boot_seq i_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_we    (boot_we),
        .boot_wdata (boot_wdata),
        .load_fire  (load_fire),
        .warm_fire  (warm_fire),
        .id_fire    (id_fire)
    );

    fsag_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .page_adv  (load_fire),
        .warm_clr  (warm_fire),
        .blk_src   (blk_src),
        .pg_src    (pg_src),
        .blk_dst   (blk_dst),
        .pg_dst    (pg_dst),
        .buf_sel   (buf_sel),
        .buf_cnt   (buf_cnt)
    );

    fsag_sector_calc i_src_calc (
        .blk_reg   (blk_src),
        .pg_reg    (pg_src),
        .dev_id    (dev_id),
        .sector    (src_sector),
        .blk_start (src_blk_start)
    );

    fsag_sector_calc i_dst_calc (
        .blk_reg   (blk_dst),
        .pg_reg    (pg_dst),
        .dev_id    (dev_id),
        .sector    (dst_sector),
        .blk_start (dst_blk_start)
    );

    assign op_code = fsag_op_e'(cmd_op);

    // Purpose: register the operation descriptor; a boot load wins over a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid      <= 1'b0;
            op_kind       <= 2'd0;
            op_sector     <= '0;
            op_dst_sector <= '0;
            op_count      <= '0;
            op_buf        <= '0;
        end else begin
            op_valid <= load_fire || cmd_valid;
            if (load_fire) begin
                op_kind       <= OP_LOAD;
                op_sector     <= src_sector;
                op_dst_sector <= '0;
                op_count      <= PAGE_CNT;
                op_buf        <= BOOT_BUF;
            end else if (cmd_valid) begin
                op_kind <= cmd_op;
                op_buf  <= buf_sel;
                case (op_code)
                    OP_COPY: begin
                        op_sector     <= src_sector;
                        op_dst_sector <= dst_sector;
                        op_count      <= CNT_W'(buf_cnt);
                    end
                    OP_ERASE: begin
                        op_sector     <= src_blk_start;
                        op_dst_sector <= '0;
                        op_count      <= BLOCK_CNT;
                    end
                    default: begin
                        op_sector     <= src_sector;
                        op_dst_sector <= '0;
                        op_count      <= CNT_W'(buf_cnt);
                    end
                endcase
            end
        end
    end

    // Purpose: register the boot-window request pulses and identity words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_rst <= 1'b0;
            id_valid <= 1'b0;
            id_bytes <= '0;
        end else begin
            warm_rst <= warm_fire;
            id_valid <= id_fire;
            if (id_fire)
                id_bytes <= {wp_stat[7:0], dev_id[7:0], mfr_id[7:0]};
        end
    end

    assert_erase_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_ERASE)
        |-> (op_count == BLOCK_CNT && op_sector[PG_W+SIP_W-1:0] == '0));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !load_fire) |=> !op_valid);

    assert_dst_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != OP_COPY) |-> op_dst_sector == '0);

    assert_boot_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && cmd_valid) |=> (op_valid && op_count == PAGE_CNT
                                      && op_buf == BOOT_BUF && op_kind == OP_LOAD));

    assert_id_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        id_fire |=> (id_valid && id_bytes[7:0] == $past(mfr_id[7:0])));
endmodule

// File: tb/test_flash_sector_addr_gen.sv
// Bench for flash_sector_addr_gen: directed corners, then seeded random
// traffic, all compared against a bench-side model of the registers.
module test_flash_sector_addr_gen;
    import fsag_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        boot_we = 1'b0;
    logic [15:0] boot_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] dev_id = '0;
    logic [15:0] mfr_id = 16'h00EC;
    logic [15:0] wp_stat = 16'h0002;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [21:0] op_sector, op_dst_sector;
    logic [8:0]  op_count;
    logic [3:0]  op_buf;
    logic        warm_rst, id_valid;
    logic [23:0] id_bytes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_addr [8];
    logic [3:0]  m_buf;
    int          m_cnt;
    bit          m_armed;

    flash_sector_addr_gen i_flash_sector_addr_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .boot_we(boot_we), .boot_wdata(boot_wdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .dev_id(dev_id),
        .mfr_id(mfr_id), .wp_stat(wp_stat), .op_valid(op_valid),
        .op_kind(op_kind), .op_sector(op_sector), .op_dst_sector(op_dst_sector),
        .op_count(op_count), .op_buf(op_buf), .warm_rst(warm_rst),
        .id_valid(id_valid), .id_bytes(id_bytes)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected block number from R1/R2, computed arithmetically.
    function automatic longint f_block(logic [15:0] b, logic [15:0] d);
        longint bn = longint'(b & 16'h0FFF);
        if (b[15] && d[3]) begin
            longint m = longint'(1) << (6 + int'(d[6:4]));
            if ((bn / m) % 2 == 0) bn = bn + m;
        end
        return bn;
    endfunction

    function automatic longint f_sector(logic [15:0] b, logic [15:0] p, logic [15:0] d);
        return f_block(b, d) * 256 + longint'(p[7:2]) * 4 + longint'(p[1:0]);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < 8; k++) m_addr[k] = '0;
        m_buf = '0;
        m_cnt = 1;
    endtask

    task automatic wr_reg(logic [3:0] sel, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel < 8) m_addr[sel] = d;
        else if (sel == 8) begin
            m_buf = d[11:8];
            m_cnt = (d[1:0] == 2'd0) ? 4 : int'(d[1:0]);
        end
    endtask

    task automatic do_cmd(logic [1:0] op, string req);
        longint es, ed;
        int ec;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        es = (op == 2'd3) ? f_block(m_addr[0], dev_id) * 256
                          : f_sector(m_addr[0], m_addr[7], dev_id);
        ed = (op == 2'd2) ? f_sector(m_addr[2], m_addr[3], dev_id) : 0;
        ec = (op == 2'd3) ? 256 : m_cnt;
        chk("R6", "op_valid", longint'(op_valid), 1);
        chk("R6", "op_kind", longint'(op_kind), longint'(op));
        chk(req, "op_sector", longint'(op_sector), es);
        chk("R3", "op_dst_sector", longint'(op_dst_sector), ed);
        chk(req, "op_count", longint'(op_count), longint'(ec));
        chk("R5", "op_buf", longint'(op_buf), longint'(m_buf));
        @(negedge clk);
        chk("R6", "op_valid low after pulse", longint'(op_valid), 0);
    endtask

    // One boot write, with the outputs checked one edge later.
    task automatic boot_wr(logic [15:0] d, string req);
        bit exp_load = 1'b0, exp_warm = 1'b0, exp_id = 1'b0;
        longint es = 0;
        if (m_armed) begin
            m_armed = 1'b0;
            if (d == 16'h0000) begin
                exp_load = 1'b1;
                es = f_sector(m_addr[0], m_addr[7], dev_id);
            end
        end else begin
            if (d == 16'h00E0) m_armed = 1'b1;
            if (d == 16'h00F0) exp_warm = 1'b1;
            if (d == 16'h0090) exp_id = 1'b1;
        end
        @(negedge clk);
        boot_we = 1'b1; boot_wdata = d;
        @(negedge clk);
        boot_we = 1'b0;
        chk(req, "op_valid on boot write", longint'(op_valid), longint'(exp_load));
        chk(req, "warm_rst", longint'(warm_rst), longint'(exp_warm));
        chk(req, "id_valid", longint'(id_valid), longint'(exp_id));
        if (exp_load) begin
            chk("R7", "boot sector", longint'(op_sector), es);
            chk("R7", "boot count", longint'(op_count), 4);
            chk("R7", "boot buf", longint'(op_buf), 8);
            chk("R7", "boot kind", longint'(op_kind), 0);
            m_addr[7] = {8'h00, m_addr[7][7:0] + 8'd4};
        end
        if (exp_warm) model_clear();
        if (exp_id)
            chk("R10", "id_bytes", longint'(id_bytes),
                longint'({wp_stat[7:0], dev_id[7:0], mfr_id[7:0]}));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h00C0FFEE));
        model_clear();
        m_armed = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "op_valid in reset", longint'(op_valid), 0);
        chk("R12", "op_sector in reset", longint'(op_sector), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "warm_rst after reset", longint'(warm_rst), 0);
        chk("R12", "id_valid after reset", longint'(id_valid), 0);
        // R5: reset count 1, buffer 0
        do_cmd(2'd0, "R5");
        // R1 and R2: extended block with density on
        dev_id = 16'h0038;
        wr_reg(4'd0, 16'h8005);
        wr_reg(4'd7, 16'h002D);
        do_cmd(2'd0, "R1");
        do_cmd(2'd1, "R1");
        dev_id = 16'h0070;        // density enable clear: mask 0 (R2)
        do_cmd(2'd0, "R2");
        dev_id = 16'h0078;        // widest density code (R2)
        wr_reg(4'd0, 16'h8FFF);
        do_cmd(2'd1, "R2");
        // R5: count code 0 means 4, and selector field
        wr_reg(4'd8, 16'h0A00);
        do_cmd(2'd0, "R5");
        wr_reg(4'd8, 16'h0302);
        do_cmd(2'd1, "R5");
        wr_reg(4'd9, 16'hFFFF);   // ignored selector (R5)
        do_cmd(2'd0, "R5");
        // R3: copy-back
        wr_reg(4'd2, 16'h8123);
        wr_reg(4'd3, 16'h00F7);
        do_cmd(2'd2, "R3");
        // R4: erase
        do_cmd(2'd3, "R4");
        // R7: boot load with wrap and upper bits cleared
        wr_reg(4'd7, 16'h12FE);
        boot_wr(16'h00E0, "R7");
        boot_wr(16'h0000, "R7");
        boot_wr(16'h00E0, "R7");
        boot_wr(16'h0000, "R7");
        do_cmd(2'd0, "R7");
        // R8: armed writes are consumed
        boot_wr(16'h00E0, "R8");
        boot_wr(16'h00F0, "R8");
        do_cmd(2'd0, "R8");
        boot_wr(16'h00E0, "R8");
        boot_wr(16'h0005, "R8");
        boot_wr(16'h0000, "R8");
        // R10: identity words
        boot_wr(16'h0090, "R10");
        // R11: boot load collides with an erase strobe
        wr_reg(4'd7, 16'h00FC);
        boot_wr(16'h00E0, "R11");
        @(negedge clk);
        boot_we = 1'b1; boot_wdata = 16'h0000;
        cmd_valid = 1'b1; cmd_op = 2'd3;
        m_armed = 1'b0;
        @(negedge clk);
        boot_we = 1'b0; cmd_valid = 1'b0;
        chk("R11", "op_count", longint'(op_count), 4);
        chk("R11", "op_buf", longint'(op_buf), 8);
        chk("R11", "op_kind", longint'(op_kind), 0);
        chk("R11", "op_sector", longint'(op_sector), f_sector(m_addr[0], m_addr[7], dev_id));
        m_addr[7] = {8'h00, m_addr[7][7:0] + 8'd4};
        do_cmd(2'd0, "R7");
        // R9: warm reset clears state
        boot_wr(16'h00F0, "R9");
        do_cmd(2'd0, "R9");
        // random traffic
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 4) begin
                logic [3:0] s = 4'($urandom_range(0, 15));
                logic [15:0] v = 16'($urandom);
                wr_reg(s, v);
            end else if (r < 8) begin
                dev_id = 16'($urandom);
                do_cmd(2'($urandom_range(0, 3)), "R1");
            end else if (r == 8) begin
                boot_wr(16'h00E0, "R7");
                boot_wr(16'h0000, "R7");
            end else begin
                logic [15:0] bv;
                case ($urandom_range(0, 3))
                    0: bv = 16'h00E0;
                    1: bv = 16'h0090;
                    2: bv = 16'h0000;
                    default: bv = 16'h00F0;
                endcase
                boot_wr(bv, "R8");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule